// File: doc/BRIEF.md
# Conversion Result Ready and Read-Collision Tracker

This block sits between a converter's result path and its serial read port. It keeps the most recent conversion result in a data register and tracks whether that result is still unread. It shows this state on two outputs: an active-low interrupt line and an active-high status bit that the serial side can return when the command register is read. The serial side marks each read of the data register with a start strobe and an end strobe. The converter marks each finished measurement with a single-cycle strobe that comes with the new result word.

The data register never changes while a read is in progress. If a result arrives during a read, the block stores it in a shadow register and raises a sticky collision flag. It does not abort the read: the read is clocked to completion, its data is treated as invalid, and the held result moves into the data register when the read ends. If a result replaces one that was never read, the ready indication drops for one cycle so that a host can see the new edge.

Top module: `drt_ready_tracker`

## Requirements
- R1: A result strobe outside any read loads `conv_data` into `data_out` and sets `drdy` on the next clock, provided no unread result is pending. `int_n` is always the inverse of `drdy`: low means ready.
- R2: When a read ends with no result arriving during its window, `drdy` is low on the next clock.
- R3: A result strobe outside any read while `drdy` is high loads the new word, drives `drdy` low for exactly one cycle, and then drives it high again.
- R4: A result strobe inside a read window sets `collision` on the next clock. The window runs from the `rd_start` cycle through the `rd_end` cycle, both included.
- R5: `data_out` does not change while a read is in progress, and the read is not cut short. A result that arrived mid-read appears in `data_out` on the clock after `rd_end`, with `drdy` high.
- R6: A result strobe in the same cycle as `rd_end` loads directly into `data_out` at that edge, sets `collision`, and leaves `drdy` high.
- R7: `collision` stays set until the next `rd_start` clears it. If a result strobe arrives in that same cycle, the flag stays set.
- R8: After a synchronous active-low reset, `drdy` is 0, `int_n` is 1, `collision` is 0 and `data_out` is 0.
- R9: If several results arrive during one read, only the last of them is loaded when the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| conv_done | input | 1 | One-cycle strobe: a measurement finished |
| conv_data | input | DATA_W | Result word, valid with `conv_done` |
| rd_start | input | 1 | One-cycle strobe: a data-register read begins |
| rd_end | input | 1 | One-cycle strobe: that read has finished clocking out |
| int_n | output | 1 | Ready interrupt, active low |
| drdy | output | 1 | Ready status bit, active high |
| data_out | output | DATA_W | Data register contents |
| collision | output | 1 | Sticky flag: the last read overlapped a new result |

## Verification
The bench targets the overlaps between strobes:
- A result that lands on the `rd_start` or `rd_end` cycle. A design that treats the window as exclusive would overwrite mid-read data or miss the collision.
- A result that arrives during the one-cycle gap after an overwrite. A design that gets this wrong would reassert ready too early or drop it for too long.
- Several results inside one read. A design that loads the first instead of the last would show stale data after the read.
- A single-cycle read where start and end coincide, which must count as a successful read.

A behavioural model using a queue for mid-read results is compared with all outputs on every clock during a long pseudo-random run.

// File: rtl/drt_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the ready/collision tracker.
// Assumes: read strobes are single-cycle pulses supplied by the serial side.
package drt_pkg;
    // Default width of one conversion result.
    localparam int DRT_DATA_W = 24;

    // Decoded read-window status handed from the window tracker to the others.
    typedef struct packed {
        logic busy;    // a read is in progress this cycle (start cycle included)
        logic end_ev;  // the read window closes this cycle
        logic hit;     // a result strobe fell inside the window
    } rdwin_t;
endpackage

// File: rtl/drt_read_window.sv
`timescale 1ns/1ps
// Module: drt_read_window
// Tracks whether a data-register read is open and keeps the sticky collision flag.
// Assumes: rd_end only counts while a read is open or is opening in the same cycle.
module drt_read_window
    import drt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rd_start,
    input  logic   rd_end,
    input  logic   conv_done,
    output rdwin_t win,
    output logic   collision
);
    logic reading_q;
    logic coll_q;

    // Combine the registered window state with the strobes of this cycle.
    always_comb begin
        win.busy   = reading_q | rd_start;
        win.end_ev = rd_end & win.busy;
        win.hit    = conv_done & win.busy;
    end

    // Open the window on rd_start and close it on rd_end.
    always_ff @(posedge clk) begin
        if (!rst_n)          reading_q <= 1'b0;
        else if (win.end_ev) reading_q <= 1'b0;
        else if (rd_start)   reading_q <= 1'b1;
    end

    // Set the collision flag on a hit; otherwise clear it when a read starts.
    always_ff @(posedge clk) begin
        if (!rst_n)        coll_q <= 1'b0;
        else if (win.hit)  coll_q <= 1'b1;
        else if (rd_start) coll_q <= 1'b0;
    end

    assign collision = coll_q;

    a_r4_hit_sets_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && (reading_q || rd_start)) |=> coll_q);
    a_r7_start_clears_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_start && !conv_done) |=> !coll_q);
endmodule

// File: rtl/drt_capture.sv
`timescale 1ns/1ps
// Module: drt_capture
// Holds the data register and a shadow register for results that arrive mid-read.
// Assumes: the data register must stay frozen for the whole read window.
module drt_capture
    import drt_pkg::*;
#(
    parameter int DATA_W = DRT_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  rdwin_t            win,
    output logic [DATA_W-1:0] data_q,
    output logic              idle_load,
    output logic              end_fresh
);
    logic [DATA_W-1:0] shadow_q;
    logic              shadow_vld_q;

    // A load outside a read, and whether fresh data exists when a read closes.
    always_comb begin
        idle_load = conv_done & ~win.busy;
        end_fresh = win.end_ev & (conv_done | shadow_vld_q);
    end

    // Hold mid-read results in the shadow register; the latest one wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q     <= '0;
            shadow_vld_q <= 1'b0;
        end else if (win.end_ev) begin
            shadow_vld_q <= 1'b0;
        end else if (win.hit) begin
            shadow_q     <= conv_data;
            shadow_vld_q <= 1'b1;
        end
    end

    // Update the data register: direct when idle, from the newest result at read end.
    always_ff @(posedge clk) begin
        if (!rst_n)                          data_q <= '0;
        else if (win.end_ev && conv_done)    data_q <= conv_data;
        else if (win.end_ev && shadow_vld_q) data_q <= shadow_q;
        else if (idle_load)                  data_q <= conv_data;
    end

    a_r5_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (win.busy && !win.end_ev) |=> $stable(data_q));
    a_r1_idle_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !win.busy) |=> (data_q == $past(conv_data)));
    a_r9_latest_shadowed: assert property (@(posedge clk) disable iff (!rst_n)
        (win.hit && !win.end_ev) |=> (shadow_vld_q && shadow_q == $past(conv_data)));
endmodule

// File: rtl/drt_flags.sv
`timescale 1ns/1ps
// Module: drt_flags
// Ready flag with a one-cycle gap inserted when an unread result is replaced.
// Assumes: the load and read-end qualifiers come from drt_capture/drt_read_window.
module drt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic idle_load,
    input  logic end_ev,
    input  logic end_fresh,
    output logic ready
);
    logic ready_q;
    logic gap_q;

    // Sequence ready: a read end decides it, an overwrite opens a gap, and the gap then closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
            gap_q   <= 1'b0;
        end else if (end_ev) begin
            ready_q <= end_fresh;
            gap_q   <= 1'b0;
        end else if (idle_load) begin
            if (ready_q || gap_q) begin
                ready_q <= 1'b0;
                gap_q   <= 1'b1;
            end else begin
                ready_q <= 1'b1;
            end
        end else if (gap_q) begin
            ready_q <= 1'b1;
            gap_q   <= 1'b0;
        end
    end

    assign ready = ready_q;

    a_r3_overwrite_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_load && !end_ev && ready_q) |=> (!ready_q && gap_q));
    a_r3_gap_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q && !end_ev && !idle_load) |=> ready_q);
    a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (end_ev && !end_fresh) |=> !ready_q);
endmodule

// File: rtl/drt_ready_tracker.sv
`timescale 1ns/1ps
// Module: drt_ready_tracker (top)
// Tracks whether the result register is unread, drives the active-low interrupt and
// the active-high status bit, and flags reads that overlap a new result.
// Assumes: all strobes are synchronous to clk and one cycle wide.
module drt_ready_tracker
    import drt_pkg::*;
#(
    parameter int DATA_W = DRT_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              rd_start,
    input  logic              rd_end,
    output logic              int_n,
    output logic              drdy,
    output logic [DATA_W-1:0] data_out,
    output logic              collision
);
    rdwin_t win;
    logic   idle_load;
    logic   end_fresh;
    logic   ready;

    drt_read_window u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .rd_end    (rd_end),
        .conv_done (conv_done),
        .win       (win),
        .collision (collision)
    );

    drt_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .conv_data (conv_data),
        .win       (win),
        .data_q    (data_out),
        .idle_load (idle_load),
        .end_fresh (end_fresh)
    );

    drt_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_load (idle_load),
        .end_ev    (win.end_ev),
        .end_fresh (end_fresh),
        .ready     (ready)
    );

    // Present the ready state in both polarities.
    always_comb begin
        drdy  = ready;
        int_n = ~ready;
    end

    a_r6_end_hit_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (win.end_ev && conv_done) |=> (drdy && collision && data_out == $past(conv_data)));
    a_r5_collided_read_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (win.end_ev && collision && !rd_start) |=> drdy);
endmodule

// File: tb/drt_ready_tracker_tb_top.sv
`timescale 1ns/1ps
module drt_ready_tracker_tb_top;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_done = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         rd_start = 1'b0;
    logic         rd_end = 1'b0;
    logic         int_n, drdy, collision;
    logic [W-1:0] data_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    drt_ready_tracker #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .rd_start(rd_start), .rd_end(rd_end), .int_n(int_n), .drdy(drdy),
        .data_out(data_out), .collision(collision)
    );

    // Behavioural reference model, updated at each rising edge.
    bit           m_ready, m_gap, m_read, m_coll;
    logic [W-1:0] m_data;
    logic [W-1:0] m_q[$];

    always @(posedge clk) begin
        bit busy, endv;
        if (!rst_n) begin
            m_ready = 0; m_gap = 0; m_read = 0; m_coll = 0; m_data = '0; m_q.delete();
        end else begin
            busy = m_read || rd_start;
            endv = rd_end && busy;
            if (conv_done && busy) m_coll = 1;
            else if (rd_start) m_coll = 0;
            if (endv) begin
                m_ready = conv_done || (m_q.size() > 0);
                if (conv_done) m_data = conv_data;
                else if (m_q.size() > 0) m_data = m_q[$];
                m_q.delete();
                m_gap = 0;
                m_read = 0;
            end else begin
                if (rd_start) m_read = 1;
                if (conv_done && busy) m_q.push_back(conv_data);
                else if (conv_done) begin
                    m_data = conv_data;
                    if (m_ready || m_gap) begin m_ready = 0; m_gap = 1; end
                    else m_ready = 1;
                end else if (m_gap) begin
                    m_ready = 1; m_gap = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every output against the model at each falling edge after reset.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(drdy == m_ready, "R3 model drdy", W'(drdy), W'(m_ready));
            chk(int_n == !m_ready, "R1 model int_n", W'(int_n), W'(!m_ready));
            chk(collision == m_coll, "R7 model collision", W'(collision), W'(m_coll));
            chk(data_out == m_data, "R5 model data", data_out, m_data);
        end
    end

    // Drive one cycle of stimulus, then return at the next falling edge.
    task automatic cyc(input bit cd, input logic [W-1:0] v, input bit rs, input bit re);
        conv_done = cd; conv_data = v; rd_start = rs; rd_end = re;
        @(negedge clk);
        conv_done = 0; rd_start = 0; rd_end = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        done = 1;
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        bit reading;
        int rlen;
        repeat (3) @(negedge clk);
        chk(drdy == 0 && int_n == 1 && collision == 0 && data_out == 0, "R8 reset state",
            {data_out[W-4:0], drdy, int_n, collision}, 24'h2);
        rst_n = 1;
        cyc(0, '0, 0, 0);
        cyc(1, 24'hA1A1A1, 0, 0);
        chk(drdy == 1 && int_n == 0 && data_out == 24'hA1A1A1, "R1 idle load", data_out, 24'hA1A1A1);
        cyc(1, 24'hB2B2B2, 0, 0);
        chk(drdy == 0 && data_out == 24'hB2B2B2, "R3 gap cycle", W'(drdy), 24'h0);
        cyc(0, '0, 0, 0);
        chk(drdy == 1, "R3 ready after gap", W'(drdy), 24'h1);
        cyc(0, '0, 1, 0);
        cyc(0, '0, 0, 1);
        chk(drdy == 0 && collision == 0, "R2 successful read", W'(drdy), 24'h0);
        cyc(1, 24'hC3C3C3, 0, 0);
        cyc(0, '0, 1, 0);
        cyc(1, 24'hD4D4D4, 0, 0);
        chk(collision == 1, "R4 collision set", W'(collision), 24'h1);
        chk(data_out == 24'hC3C3C3, "R5 data frozen", data_out, 24'hC3C3C3);
        cyc(1, 24'hE5E5E5, 0, 0);
        cyc(0, '0, 0, 0);
        chk(data_out == 24'hC3C3C3, "R5 read continues", data_out, 24'hC3C3C3);
        cyc(0, '0, 0, 1);
        chk(data_out == 24'hE5E5E5 && drdy == 1, "R9 last result loaded", data_out, 24'hE5E5E5);
        cyc(0, '0, 0, 0);
        chk(collision == 1, "R7 sticky", W'(collision), 24'h1);
        cyc(0, '0, 1, 0);
        chk(collision == 0, "R7 cleared by start", W'(collision), 24'h0);
        cyc(1, 24'hF6F6F6, 0, 1);
        chk(data_out == 24'hF6F6F6 && drdy == 1 && collision == 1, "R6 result at read end",
            data_out, 24'hF6F6F6);
        cyc(1, 24'h0F0F0F, 1, 0);
        chk(collision == 1, "R7 start with hit keeps flag", W'(collision), 24'h1);
        cyc(0, '0, 0, 1);
        cyc(0, '0, 1, 1);
        chk(drdy == 0, "R2 single-cycle read", W'(drdy), 24'h0);
        lfsr = 16'hACE1;
        reading = 0;
        rlen = 0;
        for (int i = 0; i < 4000; i++) begin
            bit cd, rs, re;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cd = (lfsr[2:0] == 3'd0);
            rs = 0; re = 0;
            if (!reading && lfsr[5:3] == 3'd1) begin
                rs = 1; rlen = int'(lfsr[8:6]);
                if (rlen == 0) re = 1; else reading = 1;
            end else if (reading) begin
                rlen--;
                if (rlen == 0) begin re = 1; reading = 0; end
            end
            cyc(cd, {lfsr[7:0], lfsr}, rs, re);
        end
        done = 1;
        summary();
    end
endmodule